// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block turns single-byte memory requests from a core into bus cycles on a narrow external memory interface. The low address byte and the data byte share one 8-bit pad group in time. A second 8-bit pad group carries the high address byte. Each access begins with an address phase. In that phase the low address is driven and an address-latch strobe goes high, so that an external transparent latch can hold it. The access then moves to a data phase on the same pads, qualified by an active-low read strobe or write strobe.

A one-byte control register holds two settings. Bit 7 enables the external bus. Bit 6 adds one wait cycle to the data phase. While the bus is disabled, both pad groups pass through the core's general-purpose output values and enables, and requests are ignored. The block drives pad output enables instead of tri-state pads. While an access is in flight, `busy` stalls the core. Read data is returned with a one-cycle `rdValid` pulse.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset the bus is disabled and the wait bit is clear. `ale` is 0, `rdN` and `wrN` are 1, and `busy` and `rdValid` are 0.
- R2: While the enable bit is clear and no access is in flight, `adOut`, `adOe` and `hiAddr` equal `gpioAdOut`, `gpioAdOe` and `gpioHiOut`. A request produces no bus cycle and `busy` stays 0.
- R3: A request is accepted on a clock edge where `reqValid` is 1, the bus is enabled and the block is idle. For the following cycle only, `ale` is 1, `adOe` is all ones, `adOut` is `reqAddr[7:0]`, `hiAddr` is `reqAddr[15:8]`, and both strobes are high.
- R4: For a write, the cycle after the address phase has `ale` at 0, `wrN` at 0, `adOe` all ones and `adOut` equal to the write data. `wrN` is high again in the cycle after the data phase.
- R5: For a read, the cycle after the address phase is a turnaround cycle: `adOe` is all zeros, `ale` is 0 and `rdN` is still 1. `rdN` goes low in the next cycle, and `adOe` stays zero while `rdN` is low.
- R6: Read data is sampled from `adIn` on the clock edge that ends the read strobe. `rdData` then shows it, and `rdValid` is 1 for exactly the one cycle in which `rdN` has just returned high.
- R7: With the wait bit set when the request is accepted, the strobe stays low for two cycles instead of one. No strobe is ever low for more than two consecutive cycles.
- R8: No strobe is low while `ale` is high, and `rdN` and `wrN` are never low together.
- R9: `busy` is 1 from the address phase through the last strobe cycle. Requests raised while `busy` is 1 are ignored, and `hiAddr` holds the last accessed high address afterwards.
- R10: The control register is written with `ctrlWr`. Bit 7 is the enable and bit 6 is the wait select. The other bits have no effect.
- R11: Clearing the enable bit during an access lets that access finish normally. The pads revert to the general-purpose values once it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWr | input | 1 | Write strobe for the control register |
| ctrlWdata | input | 8 | Control value (bit 7 enable, bit 6 wait) |
| reqValid | input | 1 | Core request valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Byte address of the request |
| reqWdata | input | 8 | Write data |
| busy | output | 1 | Access in flight; the core must stall |
| rdValid | output | 1 | One-cycle pulse when rdData is new |
| rdData | output | 8 | Last read byte |
| adIn | input | 8 | Value sensed on the shared pads |
| adOut | output | 8 | Value driven on the shared pads |
| adOe | output | 8 | Per-pad output enable for the shared pads |
| ale | output | 1 | Address latch strobe, active high |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| hiAddr | output | 8 | High address byte pads |
| gpioAdOut | input | 8 | General-purpose value for the shared pads |
| gpioAdOe | input | 8 | General-purpose enables for the shared pads |
| gpioHiOut | input | 8 | General-purpose value for the high pads |

## Verification
Take an accepting edge as cycle 0. The address phase is then due in cycle 1. For a write, the strobe is due in cycle 2, or in cycles 2 and 3 with the wait bit set, and the release follows in the next cycle. For a read, the turnaround falls in cycle 2 and the strobe in cycle 3, or in cycles 3 and 4 with the wait bit set. `rdValid` and `rdData` are due in the cycle after the last strobe cycle. The bench raises a request half a cycle before the accepting edge, then steps one falling edge at a time and samples every pad output at each of those falling edges. A cycle that comes too early, too late or is missing therefore fails the check for its own phase. The bench's external latch and memory model record the address and data in the middle of each cycle. This confirms that what reaches the memory matches the request.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_TURN,
    ST_STRB,
    ST_XTND
  } busState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;       // capture request and wait select
    logic sampleRd;   // capture pads at the end of this cycle
    logic addrPhase;  // drive low address instead of data
    logic padDrive;   // shared pads driven by the bus
    logic ale;
    logic rdStb;
    logic wrStb;
    logic active;     // access in flight
  } busStrobes_t;

endpackage

// File: rtl/xmb_ctrl.sv
module xmb_ctrl
  import xmb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        cfgEn,
  input  logic        isWrite,
  input  logic        waitSel,
  output busStrobes_t stb
);

  busState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (reqValid && cfgEn) stateNext = ST_ADDR;
      ST_ADDR: stateNext = isWrite ? ST_STRB : ST_TURN;
      ST_TURN: stateNext = ST_STRB;
      ST_STRB: stateNext = waitSel ? ST_XTND : ST_IDLE;
      ST_XTND: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  logic inStrobe;
  logic lastStrobe;

  assign inStrobe   = (state == ST_STRB) || (state == ST_XTND);
  assign lastStrobe = ((state == ST_STRB) && !waitSel) || (state == ST_XTND);

  always_comb begin
    stb           = '0;
    stb.load      = (state == ST_IDLE) && reqValid && cfgEn;
    stb.addrPhase = (state == ST_ADDR);
    stb.ale       = (state == ST_ADDR);
    stb.padDrive  = (state == ST_ADDR) || (inStrobe && isWrite);
    stb.rdStb     = inStrobe && !isWrite;
    stb.wrStb     = inStrobe && isWrite;
    stb.sampleRd  = lastStrobe && !isWrite;
    stb.active    = (state != ST_IDLE);
  end

endmodule

// File: rtl/xmb_datapath.sv
module xmb_datapath
  import xmb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int CFG_W    = 8,
  parameter int EN_BIT   = 7,
  parameter int WAIT_BIT = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ctrlWr,
  input  logic [CFG_W-1:0]           ctrlWdata,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic                       reqWrite,
  input  logic [DATA_W-1:0]          reqWdata,
  input  busStrobes_t                stb,
  output logic                       cfgEn,
  output logic                       isWrite,
  output logic                       waitSel,
  output logic                       rdValid,
  output logic [DATA_W-1:0]          rdData,
  input  logic [DATA_W-1:0]          adIn,
  output logic [DATA_W-1:0]          adOut,
  output logic [DATA_W-1:0]          adOe,
  output logic                       ale,
  output logic                       rdN,
  output logic                       wrN,
  output logic [ADDR_W-DATA_W-1:0]   hiAddr,
  input  logic [DATA_W-1:0]          gpioAdOut,
  input  logic [DATA_W-1:0]          gpioAdOe,
  input  logic [ADDR_W-DATA_W-1:0]   gpioHiOut
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic              cfgWait;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic              unusedCfgBits;

  assign unusedCfgBits = ^ctrlWdata;

  // Control register: enable and wait select only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn   <= 1'b0;
      cfgWait <= 1'b0;
    end else if (ctrlWr) begin
      cfgEn   <= ctrlWdata[EN_BIT];
      cfgWait <= ctrlWdata[WAIT_BIT];
    end
  end

  // Request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      isWrite  <= 1'b0;
      waitSel  <= 1'b0;
    end else if (stb.load) begin
      addrReg  <= reqAddr;
      wdataReg <= reqWdata;
      isWrite  <= reqWrite;
      waitSel  <= cfgWait;
    end
  end

  // Read capture on the edge that ends the read strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.sampleRd;
      if (stb.sampleRd) rdData <= adIn;
    end
  end

  logic engaged;
  assign engaged = cfgEn || stb.active;

  assign adOut  = !engaged      ? gpioAdOut :
                  stb.addrPhase ? addrReg[DATA_W-1:0] : wdataReg;
  assign hiAddr = engaged ? addrReg[ADDR_W-1:DATA_W] : gpioHiOut[HI_W-1:0];

  for (genvar i = 0; i < DATA_W; i++) begin : g_padOe
    assign adOe[i] = engaged ? stb.padDrive : gpioAdOe[i];
  end

  assign ale = stb.ale;
  assign rdN = !stb.rdStb;
  assign wrN = !stb.wrStb;

endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xmb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int CFG_W    = 8,
  parameter int EN_BIT   = 7,
  parameter int WAIT_BIT = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ctrlWr,
  input  logic [CFG_W-1:0]         ctrlWdata,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic                     busy,
  output logic                     rdValid,
  output logic [DATA_W-1:0]        rdData,
  input  logic [DATA_W-1:0]        adIn,
  output logic [DATA_W-1:0]        adOut,
  output logic [DATA_W-1:0]        adOe,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic [ADDR_W-DATA_W-1:0] hiAddr,
  input  logic [DATA_W-1:0]        gpioAdOut,
  input  logic [DATA_W-1:0]        gpioAdOe,
  input  logic [ADDR_W-DATA_W-1:0] gpioHiOut
);

  busStrobes_t stb;
  logic        cfgEn;
  logic        isWrite;
  logic        waitSel;

  xmb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cfgEn    (cfgEn),
    .isWrite  (isWrite),
    .waitSel  (waitSel),
    .stb      (stb)
  );

  xmb_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CFG_W    (CFG_W),
    .EN_BIT   (EN_BIT),
    .WAIT_BIT (WAIT_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWr    (ctrlWr),
    .ctrlWdata (ctrlWdata),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .reqWdata  (reqWdata),
    .stb       (stb),
    .cfgEn     (cfgEn),
    .isWrite   (isWrite),
    .waitSel   (waitSel),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .adIn      (adIn),
    .adOut     (adOut),
    .adOe      (adOe),
    .ale       (ale),
    .rdN       (rdN),
    .wrN       (wrN),
    .hiAddr    (hiAddr),
    .gpioAdOut (gpioAdOut),
    .gpioAdOe  (gpioAdOe),
    .gpioHiOut (gpioHiOut)
  );

  assign busy = stb.active;

endmodule

// File: rtl/xmb_checker.sv
module xmb_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ale,
  input logic              rdN,
  input logic              wrN,
  input logic [DATA_W-1:0] adOe,
  input logic              busy,
  input logic              rdValid
);

  assert_strobe_vs_ale_R8: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN));

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  assert_ale_drives_R3: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (adOe == {DATA_W{1'b1}}));

  assert_write_drives_R4: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> (adOe == {DATA_W{1'b1}}));

  assert_read_released_R5: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (adOe == '0));

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> ($past(adOe) == '0));

  assert_rd_stretch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && $past(!rdN)) |=> rdN);

  assert_wr_stretch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && $past(!wrN)) |=> wrN);

  assert_busy_cover_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ale || !rdN || !wrN) |-> busy);

  assert_rdvalid_after_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $rose(rdN));

  assert_rdvalid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

bind xmem_bus_ctrl xmb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ale     (ale),
  .rdN     (rdN),
  .wrN     (wrN),
  .adOe    (adOe),
  .busy    (busy),
  .rdValid (rdValid)
);

// File: tb/xmem_bus_ctrl_tb.sv
`timescale 1ns/1ps
module xmem_bus_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWr = 1'b0;
  logic [7:0]  ctrlWdata = '0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        busy, rdValid, ale, rdN, wrN;
  logic [7:0]  rdData, adIn, adOut, adOe, hiAddr;
  logic [7:0]  gpioAdOut = 8'h96;
  logic [7:0]  gpioAdOe  = 8'h0F;
  logic [7:0]  gpioHiOut = 8'h69;

  int nChecks = 0;
  int nErrors = 0;

  always #2.5 clk = ~clk;

  xmem_bus_ctrl u_dut (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWdata(ctrlWdata),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busy(busy), .rdValid(rdValid), .rdData(rdData), .adIn(adIn),
    .adOut(adOut), .adOe(adOe), .ale(ale), .rdN(rdN), .wrN(wrN), .hiAddr(hiAddr),
    .gpioAdOut(gpioAdOut), .gpioAdOe(gpioAdOe), .gpioHiOut(gpioHiOut)
  );

  // External latch and memory model
  logic [7:0]  latchLow = '0;
  logic [15:0] lastWrAddr = '0;
  logic [7:0]  lastWrData = '0;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    if (ale) latchLow = adOut;
    if (!wrN) begin
      lastWrAddr = {hiAddr, latchLow};
      lastWrData = adOut;
    end
  end

  assign adIn = (!rdN && adOe == 8'h00) ? pat({hiAddr, latchLow}) : 8'hEE;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setCfg(input logic [7:0] v);
    @(negedge clk);
    ctrlWr = 1'b1; ctrlWdata = v;
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  task automatic runAccess(input logic wr, input logic [15:0] a, input logic [7:0] d, input logic wt);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R3 ale", ale, 1);
    chk("R3 low addr", adOut, a[7:0]);
    chk("R3 high addr", hiAddr, a[15:8]);
    chk("R3 drive", adOe, 8'hFF);
    chk("R3 strobes idle", {rdN, wrN}, 2'b11);
    chk("R9 busy", busy, 1);
    if (wr) begin
      @(negedge clk);
      chk("R4 wr low", {ale, wrN, rdN}, 3'b001);
      chk("R4 data", adOut, d);
      chk("R4 drive", adOe, 8'hFF);
      if (wt) begin
        @(negedge clk);
        chk("R7 wr held", wrN, 0);
      end
      @(negedge clk);
      chk("R4 wr released", wrN, 1);
      chk("R9 busy done", busy, 0);
      chk("R4 mem addr", lastWrAddr, a);
      chk("R4 mem data", lastWrData, d);
    end else begin
      @(negedge clk);
      chk("R5 turnaround", {ale, rdN, wrN}, 3'b011);
      chk("R5 released", adOe, 8'h00);
      @(negedge clk);
      chk("R5 rd low", rdN, 0);
      if (wt) begin
        @(negedge clk);
        chk("R7 rd held", rdN, 0);
      end
      @(negedge clk);
      chk("R6 rd released", rdN, 1);
      chk("R6 rdValid", rdValid, 1);
      chk("R6 rdData", rdData, pat(a));
      chk("R9 busy done", busy, 0);
      @(negedge clk);
      chk("R6 pulse ends", rdValid, 0);
    end
  endtask

  // {wait, write, address, data}
  localparam logic [25:0] VEC [0:5] = '{
    {1'b0, 1'b1, 16'h1234, 8'hA5},
    {1'b0, 1'b0, 16'h1234, 8'h00},
    {1'b1, 1'b1, 16'hFF00, 8'h3C},
    {1'b1, 1'b0, 16'h00FF, 8'h00},
    {1'b0, 1'b1, 16'h8001, 8'h00},
    {1'b1, 1'b0, 16'hABCD, 8'h00}
  };

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ale", ale, 0);
    chk("R1 strobes", {rdN, wrN}, 2'b11);
    chk("R1 busy", busy, 0);
    chk("R1 rdValid", rdValid, 0);
    // R2 disabled: pass-through and ignored request
    chk("R2 adOut", adOut, gpioAdOut);
    chk("R2 adOe", adOe, gpioAdOe);
    chk("R2 hiAddr", hiAddr, gpioHiOut);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 16'h2222;
    repeat (2) @(negedge clk);
    chk("R2 no cycle", {busy, ale, rdN, wrN}, 4'b0011);
    reqValid = 1'b0;
    // R10 only bits 7 and 6 count
    setCfg(8'h3F);
    reqValid = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 other bits ignored", {busy, ale}, 2'b00);
    chk("R10 still gpio", adOut, gpioAdOut);
    reqValid = 1'b0;

    // Vector table
    for (int i = 0; i < 6; i++) begin
      logic [25:0] v;
      v = VEC[i];
      setCfg(v[25] ? 8'hC0 : 8'h80);
      runAccess(v[24], v[23:8], v[7:0], v[25]);
    end

    // R9 request during busy ignored
    setCfg(8'h80);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 16'h5511; reqWdata = 8'h77;
    @(negedge clk);
    reqAddr = 16'h9922; reqWdata = 8'h11;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R9 first access", {wrN, hiAddr}, {1'b0, 8'h55});
    @(negedge clk);
    chk("R9 done", busy, 0);
    chk("R9 mem", {lastWrAddr, lastWrData}, {16'h5511, 8'h77});
    @(negedge clk);
    chk("R9 no second access", {busy, ale}, 2'b00);
    chk("R9 hiAddr held", hiAddr, 8'h55);

    // R11 disable during read
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 16'h4321;
    @(negedge clk);
    reqValid = 1'b0; ctrlWr = 1'b1; ctrlWdata = 8'h00;
    @(negedge clk);
    ctrlWr = 1'b0;
    chk("R11 turnaround", {rdN, adOe}, {1'b1, 8'h00});
    @(negedge clk);
    chk("R11 strobe", rdN, 0);
    @(negedge clk);
    chk("R11 completes", {rdValid, rdData}, {1'b1, pat(16'h4321)});
    chk("R11 gpio back", adOut, gpioAdOut);
    chk("R11 gpio oe", adOe, gpioAdOe);
    chk("R11 gpio high", hiAddr, gpioHiOut);

    // R1 reset mid-access
    setCfg(8'h80);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 16'h0101;
    @(negedge clk);
    reqValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    chk("R1 async reset", {busy, ale, rdN, wrN}, 4'b0011);
    chk("R1 disabled after reset", adOut, gpioAdOut);
    rstN = 1'b1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nErrors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule